// File: doc/BRIEF.md
# Bidirectional Byte-Flagged Mailbox Exchange

This block lets two agents on a chip, a host side and a local side, pass 32-bit words to each other through a set of shared mailboxes. Each side has a plain register port with a write strobe, a read strobe, a word address, byte enables and read data. Each side sees four outgoing and four incoming mailboxes. A mailbox that one side writes as outgoing is the same storage the other side reads as incoming.

Every mailbox byte carries a full flag. A write sets the flags of the enabled bytes. A read of an incoming mailbox clears the flags of the enabled bytes. Each side reads every flag through its own read-only status word, so the two views always mirror each other. Either side can clear all flags at once.

Each side has two interrupt triggers it can arm separately. One watches a chosen incoming byte becoming full. The other watches a chosen outgoing byte becoming empty. A trigger that fires latches a sticky pending bit and pulls that side's active-low interrupt line. Software clears the pending bit by writing one to it.

Top module: `mbx_exchange`

## Requirements
- R1: Word addresses on each side decode as follows. Addresses 0..3 are outgoing mailboxes 1..4: a write stores data, and a read returns the stored word without touching any flag. Addresses 4..7 are incoming mailboxes 1..4, which are read-only. Address 8 is status. Address 9 is interrupt control. Data written to outgoing mailbox N on one side is read back from incoming mailbox N on the other side.
- R2: A write to an outgoing mailbox changes only the bytes whose enable bit is high (byte b is bits 8b+7..8b). It sets the full flag of exactly those bytes.
- R3: In a side's status word, bit 4*m+b holds the flag of outgoing mailbox m+1, byte b. Bit 16+4*m+b holds the flag of incoming mailbox m+1, byte b.
- R4: Bits 31..16 of one side's status word always equal bits 15..0 of the other side's status word, and the reverse also holds.
- R5: A read of an incoming mailbox clears the flags of exactly the enabled bytes, and the cleared flags disappear from both status views. Reads of outgoing mailboxes, status or control clear nothing. Writes to the status address or to incoming mailbox addresses change neither flags nor data.
- R6: A control write with bit 24 set clears all 32 flags in both directions. Mailbox data is kept.
- R7: When a write to a byte falls in the same cycle as a read or a global clear that would clear that byte, the write wins and the flag ends set.
- R8: The control word holds the full trigger and the empty trigger. The full trigger is bit 0 enable, bits 2:1 mailbox index (0 = mailbox 1) and bits 4:3 byte index. The empty trigger is bit 8 enable, bits 10:9 mailbox index and bits 12:11 byte index. Reads return these fields, with the full pending bit at bit 16 and the empty pending bit at bit 17. Control writes ignore byte enables.
- R9: While the full trigger is enabled, a 0-to-1 change of the selected incoming byte flag sets the full pending bit in the same clock edge. A flag that is already full sets nothing.
- R10: While the empty trigger is enabled, a 1-to-0 change of the selected outgoing byte flag sets the empty pending bit. The change can come from the other side's read or from a global clear.
- R11: Pending bits stay set until a control write puts a one in their bit position. A side's interrupt output is low exactly while at least one of its pending bits is set.
- R12: After reset all flags, pending bits and trigger fields are zero, all mailbox data reads as zero, and both interrupt outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects on incoming mailbox) |
| h_addr | input | 4 | Host word address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from address |
| h_irq_n | output | 1 | Host interrupt, active low |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 4 | Local word address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, combinational from address |
| l_irq_n | output | 1 | Local interrupt, active low |

## Verification
The properties assume that neither side raises its write and read strobes in the same cycle. The check that a status-address write leaves the flags alone assumes the other side is idle during that cycle. The stimulus drives a single operation per side per cycle and keeps the other side quiet, with two exceptions: the deliberate collision cycles that check write priority pair one side's write with the other side's read or clear, and never overlap a status write. Addresses stay within 0..9.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int unsigned DW    = 32;
    parameter int unsigned NMBX  = 4;
    parameter int unsigned AW    = 4;
    localparam int unsigned NBYTE = DW / 8;
    localparam int unsigned NFLAG = NMBX * NBYTE;
    localparam int unsigned MW    = $clog2(NMBX);
    localparam int unsigned BW    = $clog2(NBYTE);
    localparam int unsigned FW    = MW + BW;

    localparam logic [AW-1:0] A_STAT = AW'(2 * NMBX);
    localparam logic [AW-1:0] A_CTRL = AW'(2 * NMBX + 1);

    localparam int unsigned CF_FULL_LSB  = 0;
    localparam int unsigned CF_EMPTY_LSB = 8;
    localparam int unsigned CP_FULL      = 16;
    localparam int unsigned CP_EMPTY     = 17;
    localparam int unsigned CR_FLUSH     = 24;

    typedef enum logic [2:0] {
        K_OUT,
        K_IN,
        K_STAT,
        K_CTRL,
        K_NONE
    } acc_kind_t;

    typedef struct packed {
        logic [BW-1:0] byte_sel;
        logic [MW-1:0] mbx_sel;
        logic          en;
    } trig_t;

    localparam int unsigned TW = $bits(trig_t);

    function automatic acc_kind_t decode_addr(input logic [AW-1:0] a);
        if (a < AW'(NMBX))          return K_OUT;
        else if (a < AW'(2 * NMBX)) return K_IN;
        else if (a == A_STAT)       return K_STAT;
        else if (a == A_CTRL)       return K_CTRL;
        else                        return K_NONE;
    endfunction

    function automatic logic [FW-1:0] flag_idx(input trig_t t);
        return {t.mbx_sel, t.byte_sel};
    endfunction
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NFLAG-1:0]          wr_strb,
    input  logic [DW-1:0]             wdata,
    input  logic [NFLAG-1:0]          rd_strb,
    input  logic                      clr_all,
    output logic [NMBX-1:0][DW-1:0]   data,
    output logic [NFLAG-1:0]          flags,
    output logic [NFLAG-1:0]          rise,
    output logic [NFLAG-1:0]          fall
);
    logic [NFLAG-1:0] flags_d;

    // writes override both reads and global clear
    always_comb begin
        flags_d = (flags & ~rd_strb & {NFLAG{~clr_all}}) | wr_strb;
        rise    = flags_d & ~flags;
        fall    = flags & ~flags_d;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_d;
    end

    for (genvar m = 0; m < NMBX; m++) begin : g_mbx
        for (genvar b = 0; b < NBYTE; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    data[m][8*b +: 8] <= '0;
                else if (wr_strb[m*NBYTE + b])
                    data[m][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic                      rd,
    input  logic [AW-1:0]             addr,
    input  logic [NBYTE-1:0]          be,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    output logic                      irq_n,
    input  logic [NMBX-1:0][DW-1:0]   out_data,
    input  logic [NMBX-1:0][DW-1:0]   in_data,
    input  logic [NFLAG-1:0]          out_flags,
    input  logic [NFLAG-1:0]          in_flags,
    input  logic [NFLAG-1:0]          out_fall,
    input  logic [NFLAG-1:0]          in_rise,
    output logic [NFLAG-1:0]          out_wr_strb,
    output logic [NFLAG-1:0]          in_rd_strb,
    output logic                      clr_req
);
    acc_kind_t      kind;
    logic [MW-1:0]  sel;
    logic           ctrl_wr;
    trig_t          full_cfg;
    trig_t          empty_cfg;
    logic           pend_full;
    logic           pend_empty;
    logic           full_hit;
    logic           empty_hit;
    logic           wdata_unused;

    assign kind         = decode_addr(addr);
    assign sel          = addr[MW-1:0];
    assign ctrl_wr      = wr && (kind == K_CTRL);
    assign clr_req      = ctrl_wr && wdata[CR_FLUSH];
    assign wdata_unused = ^wdata;

    for (genvar m = 0; m < NMBX; m++) begin : g_strb
        assign out_wr_strb[m*NBYTE +: NBYTE] =
            (wr && kind == K_OUT && sel == MW'(m)) ? be : '0;
        assign in_rd_strb[m*NBYTE +: NBYTE] =
            (rd && kind == K_IN && sel == MW'(m)) ? be : '0;
    end

    assign full_hit  = full_cfg.en  && in_rise[flag_idx(full_cfg)];
    assign empty_hit = empty_cfg.en && out_fall[flag_idx(empty_cfg)];

    always_ff @(posedge clk) begin
        if (rst) begin
            full_cfg   <= '0;
            empty_cfg  <= '0;
            pend_full  <= 1'b0;
            pend_empty <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                full_cfg  <= trig_t'(wdata[CF_FULL_LSB  +: TW]);
                empty_cfg <= trig_t'(wdata[CF_EMPTY_LSB +: TW]);
            end
            pend_full  <= full_hit  || (pend_full  && !(ctrl_wr && wdata[CP_FULL]));
            pend_empty <= empty_hit || (pend_empty && !(ctrl_wr && wdata[CP_EMPTY]));
        end
    end

    assign irq_n = !(pend_full || pend_empty);

    always_comb begin
        rdata = '0;
        unique case (kind)
            K_OUT:  rdata = out_data[sel];
            K_IN:   rdata = in_data[sel];
            K_STAT: begin
                rdata[NFLAG-1:0]       = out_flags;
                rdata[2*NFLAG-1:NFLAG] = in_flags;
            end
            K_CTRL: begin
                rdata[CF_FULL_LSB  +: TW] = full_cfg;
                rdata[CF_EMPTY_LSB +: TW] = empty_cfg;
                rdata[CP_FULL]            = pend_full;
                rdata[CP_EMPTY]           = pend_empty;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_exchange.sv
module mbx_exchange
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [AW-1:0]     h_addr,
    input  logic [NBYTE-1:0]  h_be,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    output logic              h_irq_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [AW-1:0]     l_addr,
    input  logic [NBYTE-1:0]  l_be,
    input  logic [DW-1:0]     l_wdata,
    output logic [DW-1:0]     l_rdata,
    output logic              l_irq_n
);
    logic [NMBX-1:0][DW-1:0] h2l_data, l2h_data;
    logic [NFLAG-1:0]        h2l_flags, l2h_flags;
    logic [NFLAG-1:0]        h2l_rise, l2h_rise, h2l_fall, l2h_fall;
    logic [NFLAG-1:0]        h_out_wr, l_out_wr, h_in_rd, l_in_rd;
    logic                    h_clr, l_clr, any_clr;

    assign any_clr = h_clr || l_clr;

    mbx_bank u_h2l (
        .clk(clk), .rst(rst),
        .wr_strb(h_out_wr), .wdata(h_wdata),
        .rd_strb(l_in_rd), .clr_all(any_clr),
        .data(h2l_data), .flags(h2l_flags),
        .rise(h2l_rise), .fall(h2l_fall)
    );

    mbx_bank u_l2h (
        .clk(clk), .rst(rst),
        .wr_strb(l_out_wr), .wdata(l_wdata),
        .rd_strb(h_in_rd), .clr_all(any_clr),
        .data(l2h_data), .flags(l2h_flags),
        .rise(l2h_rise), .fall(l2h_fall)
    );

    mbx_side u_host (
        .clk(clk), .rst(rst),
        .wr(h_wr), .rd(h_rd), .addr(h_addr), .be(h_be), .wdata(h_wdata),
        .rdata(h_rdata), .irq_n(h_irq_n),
        .out_data(h2l_data), .in_data(l2h_data),
        .out_flags(h2l_flags), .in_flags(l2h_flags),
        .out_fall(h2l_fall), .in_rise(l2h_rise),
        .out_wr_strb(h_out_wr), .in_rd_strb(h_in_rd), .clr_req(h_clr)
    );

    mbx_side u_local (
        .clk(clk), .rst(rst),
        .wr(l_wr), .rd(l_rd), .addr(l_addr), .be(l_be), .wdata(l_wdata),
        .rdata(l_rdata), .irq_n(l_irq_n),
        .out_data(l2h_data), .in_data(h2l_data),
        .out_flags(l2h_flags), .in_flags(h2l_flags),
        .out_fall(l2h_fall), .in_rise(h2l_rise),
        .out_wr_strb(l_out_wr), .in_rd_strb(l_in_rd), .clr_req(l_clr)
    );
endmodule

// File: rtl/mbx_exchange_chk.sv
module mbx_exchange_chk
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              h_wr,
    input logic              h_rd,
    input logic [AW-1:0]     h_addr,
    input logic [NBYTE-1:0]  h_be,
    input logic [DW-1:0]     h_wdata,
    input logic              h_irq_n,
    input logic              l_wr,
    input logic              l_rd,
    input logic [AW-1:0]     l_addr,
    input logic [NBYTE-1:0]  l_be,
    input logic [DW-1:0]     l_wdata,
    input logic              l_irq_n,
    input logic [NFLAG-1:0]  h2l_flags,
    input logic [NFLAG-1:0]  l2h_flags
);
    logic gclr;
    assign gclr = (h_wr && h_addr == A_CTRL && h_wdata[CR_FLUSH]) ||
                  (l_wr && l_addr == A_CTRL && l_wdata[CR_FLUSH]);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam int unsigned M = i / NBYTE;
        localparam int unsigned B = i % NBYTE;

        // R2
        h_wr_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (h_wr && h_addr == AW'(M) && h_be[B]) |=> h2l_flags[i]);

        // R2
        l_wr_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (l_wr && l_addr == AW'(M) && l_be[B]) |=> l2h_flags[i]);

        // R5
        h2l_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(h2l_flags[i]) |->
                $past((l_rd && l_addr == AW'(NMBX + M) && l_be[B]) || gclr));

        // R5
        l2h_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(l2h_flags[i]) |->
                $past((h_rd && h_addr == AW'(NMBX + M) && h_be[B]) || gclr));
    end

    // R11
    h_irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!h_irq_n && !(h_wr && h_addr == A_CTRL)) |=> !h_irq_n);

    // R11
    l_irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_irq_n && !(l_wr && l_addr == A_CTRL)) |=> !l_irq_n);

    // R5
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (h_wr && h_addr == A_STAT && !h_rd && !l_wr && !l_rd)
            |=> ($stable(h2l_flags) && $stable(l2h_flags)));
endmodule

bind mbx_exchange mbx_exchange_chk u_chk (.*);

// File: tb/test_mbx_exchange.sv
module test_mbx_exchange;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
    logic [3:0]  h_addr = 0, l_addr = 0, h_be = 0, l_be = 0;
    logic [31:0] h_wdata = 0, l_wdata = 0;
    logic [31:0] h_rdata, l_rdata;
    logic        h_irq_n, l_irq_n;

    int nchk = 0;
    int nbad = 0;

    logic [31:0] mdata [2][4];
    logic [15:0] mflag [2];

    always #10 clk = ~clk;

    mbx_exchange i_mbx_exchange (
        .clk(clk), .rst(rst),
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq_n(h_irq_n),
        .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_be(l_be),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drv(input int s, input bit w, input bit r, input logic [3:0] a,
                       input logic [3:0] be, input logic [31:0] d);
        if (s == 0) begin
            h_wr = w; h_rd = r; h_addr = a; h_be = be; h_wdata = d;
        end else begin
            l_wr = w; l_rd = r; l_addr = a; l_be = be; l_wdata = d;
        end
    endtask

    task automatic idle();
        drv(0, 0, 0, 0, 0, 0);
        drv(1, 0, 0, 0, 0, 0);
    endtask

    task automatic op(input int s, input bit w, input bit r, input logic [3:0] a,
                      input logic [3:0] be, input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        drv(s, w, r, a, be, d);
        #1 q = (s == 0) ? h_rdata : l_rdata;
        @(negedge clk);
        idle();
    endtask

    task automatic peek(input int s, input logic [3:0] a, output logic [31:0] q);
        #1 q = (s == 0) ? h_rdata : l_rdata;
        drv(s, 0, 0, a, 0, 0);
        #1 q = (s == 0) ? h_rdata : l_rdata;
        drv(s, 0, 0, 0, 0, 0);
    endtask

    function automatic logic [31:0] exp_stat(input int s);
        return {mflag[1-s], mflag[s]};
    endfunction

    task automatic model_wr(input int s, input int m, input logic [3:0] be, input logic [31:0] d);
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                mdata[s][m][8*b +: 8] = d[8*b +: 8];
                mflag[s][4*m + b] = 1'b1;
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        nbad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [31:0] q;
        for (int s = 0; s < 2; s++) begin
            mflag[s] = '0;
            for (int m = 0; m < 4; m++) mdata[s][m] = '0;
        end
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        peek(0, 8, q); chk("R12 host status", q, 32'h0);
        peek(1, 8, q); chk("R12 local status", q, 32'h0);
        peek(0, 9, q); chk("R12 host ctrl", q, 32'h0);
        peek(1, 4, q); chk("R12 local in mbx data", q, 32'h0);
        chk("R12 irq lines", {31'h0, h_irq_n & l_irq_n}, 32'h1);

        // R1 R2 R3 R4 R5 sweep over side, mailbox and byte enables
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int be = 0; be < 16; be++) begin
                    logic [31:0] d;
                    logic [3:0]  rbe;
                    d = (32'h01020304 * (be + 1)) ^ (32'(m) << 28) ^ (32'(s) << 20);
                    op(s, 1, 0, 4'(m), 4'(be), d, q);
                    model_wr(s, m, 4'(be), d);
                    peek(s, 8, q);     chk("R3 writer status", q, exp_stat(s));
                    peek(1 - s, 8, q); chk("R4 mirrored status", q, exp_stat(1 - s));
                    op(s, 0, 1, 4'(m), 4'hF, 0, q);
                    chk("R1 outgoing readback", q, mdata[s][m]);
                    peek(s, 8, q);     chk("R5 outgoing read keeps flags", q, exp_stat(s));
                    rbe = 4'(be) ^ 4'b0101;
                    op(1 - s, 0, 1, 4'(4 + m), rbe, 0, q);
                    chk("R2 incoming data merge", q, mdata[s][m]);
                    for (int b = 0; b < 4; b++)
                        if (rbe[b]) mflag[s][4*m + b] = 1'b0;
                    peek(s, 8, q);     chk("R5 read clears flags", q, exp_stat(s));
                end
            end
        end

        // R5 writes to status and incoming addresses have no effect
        op(0, 1, 0, 0, 4'h3, 32'hAAAA5555, q); model_wr(0, 0, 4'h3, 32'hAAAA5555);
        op(0, 1, 0, 8, 4'hF, 32'hFFFFFFFF, q);
        peek(0, 8, q); chk("R5 status write ignored", q, exp_stat(0));
        op(0, 1, 0, 5, 4'hF, 32'h12345678, q);
        peek(0, 8, q); chk("R5 incoming write flags", q, exp_stat(0));
        peek(0, 5, q); chk("R5 incoming write data", q, mdata[1][1]);

        // R6 global clear from host keeps data
        op(1, 1, 0, 3, 4'hF, 32'hCAFEF00D, q); model_wr(1, 3, 4'hF, 32'hCAFEF00D);
        op(0, 1, 0, 9, 4'hF, 32'h01000000, q);
        mflag[0] = '0; mflag[1] = '0;
        peek(0, 8, q); chk("R6 host clear status", q, 32'h0);
        peek(1, 8, q); chk("R6 host clear mirror", q, 32'h0);
        peek(0, 7, q); chk("R6 data kept", q, 32'hCAFEF00D);

        // R6 global clear from local side
        op(0, 1, 0, 2, 4'hF, 32'h0BADBEEF, q);
        op(1, 1, 0, 9, 4'h0, 32'h01000000, q);
        peek(1, 8, q); chk("R6 local clear status", q, 32'h0);

        // R7 write beats same-cycle read
        @(negedge clk);
        drv(0, 1, 0, 1, 4'h1, 32'h000000A5);
        drv(1, 0, 1, 5, 4'h1, 0);
        @(negedge clk); idle();
        model_wr(0, 1, 4'h1, 32'h000000A5);
        peek(0, 8, q); chk("R7 write beats read", q, exp_stat(0));

        // R7 write beats same-cycle global clear
        @(negedge clk);
        drv(0, 1, 0, 2, 4'h8, 32'h77000000);
        drv(1, 1, 0, 9, 4'h0, 32'h01000000);
        @(negedge clk); idle();
        mflag[0] = '0; mflag[1] = '0;
        model_wr(0, 2, 4'h8, 32'h77000000);
        peek(1, 8, q); chk("R7 write beats clear", q, exp_stat(1));

        // R8 host full trigger: mailbox index 2, byte 1
        op(0, 1, 0, 9, 4'h0, 32'h0000000D, q);
        peek(0, 9, q); chk("R8 ctrl readback", q, 32'h0000000D);
        op(1, 1, 0, 2, 4'h1, 32'h11, q);
        chk("R9 unselected byte no irq", {31'h0, h_irq_n}, 32'h1);
        op(1, 1, 0, 2, 4'h2, 32'h2200, q);
        chk("R9 full irq low", {31'h0, h_irq_n}, 32'h0);
        peek(0, 9, q); chk("R9 full pending", q, 32'h0001000D);
        op(0, 1, 0, 9, 4'h0, 32'h0001000D, q);
        chk("R11 w1c releases irq", {31'h0, h_irq_n}, 32'h1);
        op(1, 1, 0, 2, 4'h2, 32'h3300, q);
        chk("R9 already full no edge", {31'h0, h_irq_n}, 32'h1);
        op(0, 0, 1, 6, 4'h2, 0, q);
        op(1, 1, 0, 2, 4'h2, 32'h4400, q);
        chk("R9 refill fires", {31'h0, h_irq_n}, 32'h0);
        op(0, 1, 0, 9, 4'h0, 32'h00010000, q);
        chk("R11 clear with trigger off", {31'h0, h_irq_n}, 32'h1);
        op(0, 0, 1, 6, 4'h2, 0, q);
        op(1, 1, 0, 2, 4'h2, 32'h5500, q);
        chk("R9 disabled trigger ignored", {31'h0, h_irq_n}, 32'h1);

        // R10 local empty trigger: mailbox index 0, byte 3
        op(1, 1, 0, 9, 4'h0, 32'h00001900, q);
        op(1, 1, 0, 0, 4'h8, 32'h99000000, q);
        chk("R10 fill no empty irq", {31'h0, l_irq_n}, 32'h1);
        op(0, 0, 1, 4, 4'h8, 0, q);
        chk("R10 empty irq low", {31'h0, l_irq_n}, 32'h0);
        peek(1, 9, q); chk("R10 empty pending", q, 32'h00021900);
        op(0, 0, 1, 4, 4'h8, 0, q);
        chk("R11 pending sticky", {31'h0, l_irq_n}, 32'h0);
        op(1, 1, 0, 9, 4'h0, 32'h00021900, q);
        chk("R11 empty w1c", {31'h0, l_irq_n}, 32'h1);
        op(1, 1, 0, 0, 4'h8, 32'h98000000, q);
        op(0, 1, 0, 9, 4'h0, 32'h01000000, q);
        chk("R10 empty via global clear", {31'h0, l_irq_n}, 32'h0);
        chk("R11 host irq untouched", {31'h0, h_irq_n}, 32'h1);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule